// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the 13-bit program counter of a small microcontroller core and decides, once per clock, where the counter goes next. The low byte of the counter is open to the CPU: it can be read back, overwritten, or advanced by an offset to form a computed jump. The five upper bits cannot be reached directly. Instead, a separate 5-bit page register, written by software through its own port, supplies them whenever the low byte is written or a jump is taken.

A jump carries an 11-bit target from the opcode, and only the top two counter bits come from the page register. A low-byte write or computed add takes all five upper bits from the page register. A return reloads the whole 13-bit value from the return stack and never touches the page register. When no strobe is active, the counter advances by one if stepping is enabled, and otherwise holds. Decoding, the ALU, the stack and program memory all sit outside this block.

Top module: `pgpc_unit`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc_q` to 0x0000 and clears the page register, so `page_rd` reads 0x00.
- R2: With `step_en` high and no strobe, `pc_q` becomes `pc_q + 1` at the edge and wraps from 0x1FFF to 0x0000.
- R3: With `lo_wr` high and `lo_add` low, the next `pc_q` is {page[4:0], `lo_wdata`}.
- R4: With `lo_wr` and `lo_add` high, the next `pc_q` is {page[4:0], (`pc_q[7:0]` + `lo_wdata`) mod 256}. No carry passes into bits 12:8.
- R5: With `jmp_en` high, the next `pc_q` is {page[4:3], `jmp_target[10:0]`}.
- R6: With `ret_en` high, the next `pc_q` equals `ret_addr`.
- R7: Priority runs from reset, then `ret_en`, then `jmp_en`, then `lo_wr`, then `step_en`. With none active, `pc_q` holds.
- R8: `page_wr` stores `page_wdata[4:0]`. `page_rd` returns the stored value with bits 7:5 read as zero. No other input changes the page register.
- R9: A page write takes effect at the edge. A jump or low-byte write in the same cycle still uses the old page value.
- R10: `pcl_rd` always equals `pc_q[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the counter by one |
| lo_wr | input | 1 | Low-byte write strobe |
| lo_add | input | 1 | With `lo_wr`, add `lo_wdata` to the low byte instead of loading it |
| lo_wdata | input | 8 | Low-byte data or offset |
| jmp_en | input | 1 | Jump strobe |
| jmp_target | input | 11 | Jump target from the opcode |
| page_wr | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write data; only bits 4:0 are kept |
| ret_en | input | 1 | Return-load strobe |
| ret_addr | input | 13 | Address popped from the return stack |
| pc_q | output | 13 | Current program counter |
| pcl_rd | output | 8 | Readable low byte |
| page_rd | output | 8 | Page register readback, bits 7:5 zero |

## Verification
Each counter source (R1 to R7) takes effect at the clock edge that samples its strobe, and it shows on `pc_q` and `pcl_rd` right after that edge. A page write (R8, R9) shows on `page_rd` after the same edge and first affects a jump or low-byte write one edge later. The bench drives its inputs on the falling edge and moves its reference model at the rising edge. It compares every output on the next falling edge, so each result is checked exactly one edge after the stimulus that caused it. Directed cases cover the wrap, the carry held within the low byte, the priority conflicts and the same-cycle page write. A randomized stretch follows.

// File: rtl/pgpc_pkg.sv
// Package: shared widths and the next-source encoding for the paged PC unit.
// Assumes: PAGE_W >= PC_W - LO_W so the page register can fill the high part.
package pgpc_pkg;
    localparam int PC_W   = 13;
    localparam int LO_W   = 8;
    localparam int JMP_W  = 11;
    localparam int PAGE_W = 5;
    localparam int REG_W  = 8;

    // Which source feeds the counter at the next edge, listed by priority.
    typedef enum logic [2:0] {
        SRC_RST  = 3'd0,
        SRC_RET  = 3'd1,
        SRC_JMP  = 3'd2,
        SRC_LOW  = 3'd3,
        SRC_INC  = 3'd4,
        SRC_HOLD = 3'd5
    } pc_src_e;
endpackage

// File: rtl/pgpc_page_latch.sv
// Module: page register holding the upper address bits that software preloads.
// Assumes: only the dedicated write port changes it; a same-edge reader sees the old value.
module pgpc_page_latch #(
    parameter int PAGE_W = pgpc_pkg::PAGE_W,
    parameter int REG_W  = pgpc_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [REG_W-1:0]  rd_data
);
    localparam int PAD_W = REG_W - PAGE_W;

    // Hold the page bits; clear on reset, load the low field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en) begin
            page_q <= wdata[PAGE_W-1:0];
        end
    end

    // Readback zero-extends the stored field to register width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, page_q};
        end else begin : g_nopad
            assign rd_data = page_q[REG_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pgpc_next_sel.sv
// Module: combinational next-PC selector with fixed source priority.
// Assumes: page value is the registered one; low-byte arithmetic stays in LO_W bits.
module pgpc_next_sel
    import pgpc_pkg::*;
#(
    parameter int PC_W   = pgpc_pkg::PC_W,
    parameter int LO_W   = pgpc_pkg::LO_W,
    parameter int JMP_W  = pgpc_pkg::JMP_W,
    parameter int PAGE_W = pgpc_pkg::PAGE_W
) (
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              lo_wr,
    input  logic              lo_add,
    input  logic [LO_W-1:0]   lo_wdata,
    input  logic              jmp_en,
    input  logic [JMP_W-1:0]  jmp_target,
    input  logic              ret_en,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PAGE_W-1:0] page,
    output pc_src_e           src,
    output logic [PC_W-1:0]   pc_next
);
    localparam int HI_W   = PC_W - LO_W;
    localparam int JSEL_W = PC_W - JMP_W;

    logic [LO_W-1:0] lo_sum;
    logic [LO_W-1:0] lo_val;
    logic [PC_W-1:0] jmp_val;
    logic [PC_W-1:0] low_val;
    logic [PC_W-1:0] inc_val;

    // Pick the winning source in priority order.
    always_comb begin
        if (!rst_n)       src = SRC_RST;
        else if (ret_en)  src = SRC_RET;
        else if (jmp_en)  src = SRC_JMP;
        else if (lo_wr)   src = SRC_LOW;
        else if (step_en) src = SRC_INC;
        else              src = SRC_HOLD;
    end

    // Form the candidate addresses for each source.
    always_comb begin
        lo_sum  = pc_cur[LO_W-1:0] + lo_wdata;
        lo_val  = lo_add ? lo_sum : lo_wdata;
        low_val = {page[HI_W-1:0], lo_val};
        jmp_val = {page[PAGE_W-1 -: JSEL_W], jmp_target};
        inc_val = pc_cur + {{(PC_W-1){1'b0}}, 1'b1};
    end

    // Steer the selected candidate to the output.
    always_comb begin
        unique case (src)
            SRC_RST:  pc_next = '0;
            SRC_RET:  pc_next = ret_addr;
            SRC_JMP:  pc_next = jmp_val;
            SRC_LOW:  pc_next = low_val;
            SRC_INC:  pc_next = inc_val;
            default:  pc_next = pc_cur;
        endcase
    end
endmodule

// File: rtl/pgpc_pc_reg.sv
// Module: the program counter register and its low-byte readback.
// Assumes: the selector already resolved reset into pc_next.
module pgpc_pc_reg #(
    parameter int PC_W = pgpc_pkg::PC_W,
    parameter int LO_W = pgpc_pkg::LO_W
) (
    input  logic            clk,
    input  logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] pc_q,
    output logic [LO_W-1:0] lo_rd
);
    // Capture the chosen next address every edge.
    always_ff @(posedge clk) begin
        pc_q <= pc_next;
    end

    assign lo_rd = pc_q[LO_W-1:0];
endmodule

// File: rtl/pgpc_unit.sv
// Module: paged program counter top; joins page register, selector and PC register.
// Assumes: strobes are single-cycle qualified by the core; reset is synchronous active low.
module pgpc_unit
    import pgpc_pkg::*;
#(
    parameter int PC_W   = pgpc_pkg::PC_W,
    parameter int LO_W   = pgpc_pkg::LO_W,
    parameter int JMP_W  = pgpc_pkg::JMP_W,
    parameter int PAGE_W = pgpc_pkg::PAGE_W,
    parameter int REG_W  = pgpc_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             lo_wr,
    input  logic             lo_add,
    input  logic [LO_W-1:0]  lo_wdata,
    input  logic             jmp_en,
    input  logic [JMP_W-1:0] jmp_target,
    input  logic             page_wr,
    input  logic [REG_W-1:0] page_wdata,
    input  logic             ret_en,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  pc_q,
    output logic [LO_W-1:0]  pcl_rd,
    output logic [REG_W-1:0] page_rd
);
    logic [PAGE_W-1:0] page_q;
    logic [PC_W-1:0]   pc_next;
    pc_src_e           src;

    pgpc_page_latch #(.PAGE_W(PAGE_W), .REG_W(REG_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (page_wr),
        .wdata   (page_wdata),
        .page_q  (page_q),
        .rd_data (page_rd)
    );

    pgpc_next_sel #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .PAGE_W(PAGE_W)) u_sel (
        .rst_n      (rst_n),
        .step_en    (step_en),
        .lo_wr      (lo_wr),
        .lo_add     (lo_add),
        .lo_wdata   (lo_wdata),
        .jmp_en     (jmp_en),
        .jmp_target (jmp_target),
        .ret_en     (ret_en),
        .ret_addr   (ret_addr),
        .pc_cur     (pc_q),
        .page       (page_q),
        .src        (src),
        .pc_next    (pc_next)
    );

    pgpc_pc_reg #(.PC_W(PC_W), .LO_W(LO_W)) u_pc (
        .clk     (clk),
        .pc_next (pc_next),
        .pc_q    (pc_q),
        .lo_rd   (pcl_rd)
    );
endmodule

// File: rtl/pgpc_chk.sv
// Module: property checker for pgpc_unit, attached by bind.
// Assumes: default widths (13-bit PC, 8-bit low byte, 11-bit jump field, 5-bit page).
module pgpc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_en,
    input logic        lo_wr,
    input logic        lo_add,
    input logic [7:0]  lo_wdata,
    input logic        jmp_en,
    input logic [10:0] jmp_target,
    input logic        page_wr,
    input logic [7:0]  page_wdata,
    input logic        ret_en,
    input logic [12:0] ret_addr,
    input logic [12:0] pc_q,
    input logic [7:0]  pcl_rd,
    input logic [7:0]  page_rd
);
    logic rst_was_low;

    // Remember whether the previous edge sampled reset.
    always_ff @(posedge clk) begin
        rst_was_low <= !rst_n;
    end

    // After a reset edge the counter and page readback are zero.
    always @(posedge clk) begin
        if (rst_was_low) begin
            AST_RESET_CLEARS: assert (pc_q == 13'h0 && page_rd == 8'h00); // R1
        end
    end

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> pc_q == $past(ret_addr)); // R6

    AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_en && jmp_en) |=> (pc_q[10:0] == $past(jmp_target)
                                 && pc_q[12:11] == $past(page_rd[4:3]))); // R5

    AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_en && !jmp_en && lo_wr) |=> pc_q[12:8] == $past(page_rd[4:0])); // R3

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_en && !jmp_en && !lo_wr && step_en) |=> pc_q == $past(pc_q) + 13'd1); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_en && !jmp_en && !lo_wr && !step_en) |=> $stable(pc_q)); // R7

    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(page_rd)); // R8

    AST_PAGE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        page_rd[7:5] == 3'b000); // R8
endmodule

bind pgpc_unit pgpc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .lo_wr      (lo_wr),
    .lo_add     (lo_add),
    .lo_wdata   (lo_wdata),
    .jmp_en     (jmp_en),
    .jmp_target (jmp_target),
    .page_wr    (page_wr),
    .page_wdata (page_wdata),
    .ret_en     (ret_en),
    .ret_addr   (ret_addr),
    .pc_q       (pc_q),
    .pcl_rd     (pcl_rd),
    .page_rd    (page_rd)
);

// File: tb/sim_pgpc_unit.sv
module sim_pgpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        lo_wr = 1'b0;
    logic        lo_add = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic        jmp_en = 1'b0;
    logic [10:0] jmp_target = '0;
    logic        page_wr = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        ret_en = 1'b0;
    logic [12:0] ret_addr = '0;
    logic [12:0] pc_q;
    logic [7:0]  pcl_rd;
    logic [7:0]  page_rd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int m_pc = 0;
    int m_pg = 0;

    always #4 clk = ~clk;

    pgpc_unit u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_wr(lo_wr), .lo_add(lo_add),
        .lo_wdata(lo_wdata), .jmp_en(jmp_en), .jmp_target(jmp_target),
        .page_wr(page_wr), .page_wdata(page_wdata), .ret_en(ret_en),
        .ret_addr(ret_addr), .pc_q(pc_q), .pcl_rd(pcl_rd), .page_rd(page_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst_n = 1'b1; step_en = 1'b0; lo_wr = 1'b0; lo_add = 1'b0; jmp_en = 1'b0;
        page_wr = 1'b0; ret_en = 1'b0;
    endtask

    // One clock: advance the reference model at the rising edge, compare on the falling edge.
    task automatic tick(input string tag);
        int new_pg;
        @(posedge clk);
        if (!rst_n) begin
            m_pc = 0; m_pg = 0;
        end else begin
            new_pg = page_wr ? (int'(page_wdata) & 31) : m_pg;
            if (ret_en)       m_pc = int'(ret_addr);
            else if (jmp_en)  m_pc = (((m_pg >> 3) & 3) << 11) | int'(jmp_target);
            else if (lo_wr)   m_pc = (m_pg << 8) | (lo_add ? ((m_pc + int'(lo_wdata)) & 255)
                                                           : int'(lo_wdata));
            else if (step_en) m_pc = (m_pc + 1) & 8191;
            m_pg = new_pg;
        end
        @(negedge clk);
        check(tag, int'(pc_q), m_pc);
        check("R10 low byte readback", int'(pcl_rd), m_pc & 255);
        check("R8 page readback", int'(page_rd), m_pg);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        tick("R1 reset clears");
        tick("R1 reset clears");
        idle_inputs();
        tick("R7 idle hold");
        step_en = 1'b1;
        for (int i = 0; i < 4; i++) tick("R2 step");
        idle_inputs(); ret_en = 1'b1; ret_addr = 13'h1FFE;
        tick("R6 return load");
        idle_inputs(); step_en = 1'b1;
        tick("R2 step to top");
        tick("R2 wrap to zero");
        tick("R2 step after wrap");
        // Page write with all high bits set: only the low field is kept.
        idle_inputs(); page_wr = 1'b1; page_wdata = 8'hF5;
        tick("R8 page store");
        idle_inputs(); lo_wr = 1'b1; lo_wdata = 8'hF0;
        tick("R3 low write");
        idle_inputs(); lo_wr = 1'b1; lo_add = 1'b1; lo_wdata = 8'h20;
        tick("R4 computed add no carry");
        idle_inputs(); jmp_en = 1'b1; jmp_target = 11'h5A3;
        tick("R5 jump with page bits");
        // Same-cycle page write uses the old page for the low write.
        idle_inputs(); page_wr = 1'b1; page_wdata = 8'h0A; lo_wr = 1'b1; lo_wdata = 8'h33;
        tick("R9 old page on same edge");
        idle_inputs(); lo_wr = 1'b1; lo_wdata = 8'h44;
        tick("R9 new page next edge");
        // Priority conflicts.
        idle_inputs(); ret_en = 1'b1; ret_addr = 13'h0ABC; jmp_en = 1'b1; jmp_target = 11'h111;
        lo_wr = 1'b1; lo_wdata = 8'h77; step_en = 1'b1;
        tick("R7 return beats all");
        idle_inputs(); jmp_en = 1'b1; jmp_target = 11'h222; lo_wr = 1'b1; step_en = 1'b1;
        tick("R7 jump beats low write");
        idle_inputs(); lo_wr = 1'b1; lo_wdata = 8'h99; step_en = 1'b1;
        tick("R7 low write beats step");
        idle_inputs(); ret_en = 1'b1; ret_addr = 13'h1234;
        tick("R8 return leaves page");
        idle_inputs();
        tick("R7 idle hold");
        rst_n = 1'b0; step_en = 1'b1; ret_en = 1'b1; ret_addr = 13'h0FFF;
        tick("R1 reset beats return");
        // Randomized stretch.
        for (int i = 0; i < 600; i++) begin
            rst_n      = ($urandom_range(0, 49) != 0);
            step_en    = $urandom_range(0, 1) == 1;
            lo_wr      = $urandom_range(0, 5) == 0;
            lo_add     = $urandom_range(0, 1) == 1;
            lo_wdata   = 8'($urandom);
            jmp_en     = $urandom_range(0, 7) == 0;
            jmp_target = 11'($urandom);
            page_wr    = $urandom_range(0, 5) == 0;
            page_wdata = 8'($urandom);
            ret_en     = $urandom_range(0, 9) == 0;
            ret_addr   = 13'($urandom);
            tick("R7 random mix");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule